// File: doc/BRIEF.md
# Single to half precision narrower

This block turns a 32-bit IEEE-754 single-precision word into a 16-bit half-precision word. It always rounds to nearest, with ties going to the even neighbour. Each operand arrives with a valid strobe. The result and its valid strobe appear after one register stage. A flag marks operands that are signalling NaNs.

Zeros and infinities keep their sign. A NaN can be narrowed in one of two ways, picked by a control input:

- Keep its payload: the top fraction bits are kept and the result is forced quiet.
- Replace it with the canonical half NaN 0x7E00.

Finite operands are rounded once. The result is one of these:

- a half normal;
- a half subnormal, where the denormalising shift folds every lost bit into the sticky bit;
- a signed zero;
- a signed infinity, when the rounded magnitude passes the largest finite half.

The output stage is a two-state machine:

- `ST_IDLE` means no result was produced in the last cycle.
- `ST_EMIT` means the result register holds a result presented this cycle.

Transition *accept* (`in_valid` high) goes from either state to `ST_EMIT` and loads the result register. Transition *drain* (`in_valid` low) goes from either state to `ST_IDLE` and leaves the result register unchanged. Reset enters `ST_IDLE` and clears the result.

Top module: `sp_to_hp_narrow`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high; reset clears `out_valid`, `out_word` and `out_invalid`.
- R2: An operand with exponent field 0 and fraction 0 gives 0x0000, or 0x8000 when bit 31 is set.
- R3: An operand with exponent field 0xFF and fraction 0 gives 0x7C00, or 0xFC00 when bit 31 is set.
- R4: With `dflt_nan` low, a NaN operand (exponent field 0xFF, fraction nonzero) gives: bit 15 equal to the operand's bit 31, bits 14:10 all ones, bit 9 forced to 1, and bits 8:0 equal to operand bits 21:13.
- R5: With `dflt_nan` high, every NaN operand gives 0x7E00, whatever its sign and payload.
- R6: `out_invalid` is 1 exactly when the operand was a signalling NaN, meaning exponent field 0xFF, bit 22 clear and fraction nonzero, in either NaN mode.
- R7: A normal operand whose unbiased exponent lies in -14..15 is rounded to a 10-bit half fraction on the 13 dropped bits, ties to even. A carry out of the fraction increments the exponent.
- R8: A finite operand whose rounded magnitude exceeds 0x7BFF gives a signed infinity; for example 65520.0 gives 0x7C00.
- R9: A normal operand below 2^-14 is shifted into the half subnormal range and rounded to nearest even. The guard bit is the last bit shifted out, and the sticky bit covers every other bit shifted out. It may round up to 0x0400 or down to a signed zero.
- R10: A single-precision subnormal operand (exponent field 0, fraction nonzero) gives a zero that carries the operand's sign.
- R11: In a cycle after one with `in_valid` low, `out_word` and `out_invalid` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_word | input | 32 | Single-precision operand |
| dflt_nan | input | 1 | 1: every NaN result becomes 0x7E00 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 16 | Half-precision result |
| out_invalid | output | 1 | Operand was a signalling NaN |

## Verification
Each of the three results (`out_word`, `out_invalid`, `out_valid`) is due exactly one clock edge after the cycle in which its operand was strobed. None of them depends on later inputs. The driver applies each operand at a falling edge and queues the expected result. The monitor pops the queue at the next falling edge where `out_valid` is high, so it compares half a cycle after the single register stage has loaded. An output strobe with an empty queue, or a result missing at the end, counts as a latency failure. In idle gaps the monitor checks that the last result is held.

// File: rtl/hpn_pkg.sv
package hpn_pkg;
    localparam int SRC_EXP  = 8;
    localparam int SRC_FRAC = 23;
    localparam int DST_EXP  = 5;
    localparam int DST_FRAC = 10;

    typedef enum logic [2:0] {
        K_ZERO,
        K_TINY,
        K_NORM,
        K_INF,
        K_QNAN,
        K_SNAN
    } kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } out_state_e;
endpackage

// File: rtl/hpn_classify.sv
module hpn_classify
    import hpn_pkg::*;
#(
    parameter int SE = SRC_EXP,
    parameter int SF = SRC_FRAC
) (
    input  logic [SE-1:0] exp_i,
    input  logic [SF-1:0] frac_i,
    output kind_e         kind_o
);
    logic exp_zero;
    logic exp_full;
    logic frac_zero;

    always_comb begin
        exp_zero  = (exp_i == '0);
        exp_full  = (exp_i == '1);
        frac_zero = (frac_i == '0);
        if (exp_zero && frac_zero)      kind_o = K_ZERO;
        else if (exp_zero)              kind_o = K_TINY;
        else if (exp_full && frac_zero) kind_o = K_INF;
        else if (exp_full)              kind_o = frac_i[SF-1] ? K_QNAN : K_SNAN;
        else                            kind_o = K_NORM;
    end
endmodule

// File: rtl/hpn_round.sv
module hpn_round
    import hpn_pkg::*;
#(
    parameter int SE = SRC_EXP,
    parameter int SF = SRC_FRAC,
    parameter int DE = DST_EXP,
    parameter int DF = DST_FRAC
) (
    input  logic [SE-1:0]    exp_i,
    input  logic [SF-1:0]    frac_i,
    output logic [DE+DF-1:0] mag_o
);
    localparam int BIAS_S = (1 << (SE - 1)) - 1;
    localparam int BIAS_D = (1 << (DE - 1)) - 1;
    localparam int EMIN_D = 1 - BIAS_D;
    localparam int DROP   = SF - DF;
    localparam int CAP    = SF + 3;
    localparam int W      = SF + 1;
    localparam int Z      = CAP + 1;
    localparam int EW     = SE + 2;
    localparam int MW     = DE + DF + 2;

    logic signed [EW-1:0]  e_unb;
    logic                  in_range;
    logic                  too_big;
    int                    sh;
    logic [W+Z-1:0]        shifted;
    logic [W-1:0]          kept;
    logic                  guard;
    logic                  sticky;
    logic                  bump;
    logic [MW-1:0]         base;
    logic [MW-1:0]         sum;
    logic [DE+DF-1:0]      inf_mag;

    always_comb begin
        e_unb    = $signed({2'b00, exp_i}) - EW'(BIAS_S);
        in_range = (int'(e_unb) >= EMIN_D);
        too_big  = (int'(e_unb) > BIAS_D);
        if (in_range) sh = DROP;
        else          sh = DROP + (EMIN_D - int'(e_unb));
        if (sh > CAP) sh = CAP;
        shifted  = {1'b1, frac_i, {Z{1'b0}}} >> sh;
        kept     = shifted[W+Z-1:Z];
        guard    = shifted[Z-1];
        sticky   = |shifted[Z-2:0];
        bump     = guard & (sticky | kept[0]);
        base     = in_range ? (MW'(int'(e_unb) + BIAS_D - 1) << DF) : '0;
        sum      = base + MW'(kept) + MW'(bump);
        inf_mag  = {{DE{1'b1}}, {DF{1'b0}}};
        if (too_big || (sum >= MW'(inf_mag))) mag_o = inf_mag;
        else                                  mag_o = sum[DE+DF-1:0];
    end
endmodule

// File: rtl/hpn_out_stage.sv
module hpn_out_stage
    import hpn_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d_word,
    input  logic          d_inv,
    output logic          valid,
    output logic [DW-1:0] word,
    output logic          inv
);
    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = load ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = load ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            inv  <= 1'b0;
        end else if (load) begin
            word <= d_word;
            inv  <= d_inv;
        end
    end

    assign valid = (state_q == ST_EMIT);
endmodule

// File: rtl/sp_to_hp_narrow.sv
module sp_to_hp_narrow
    import hpn_pkg::*;
#(
    parameter int SE = SRC_EXP,
    parameter int SF = SRC_FRAC,
    parameter int DE = DST_EXP,
    parameter int DF = DST_FRAC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SE+SF:0]      in_word,
    input  logic                dflt_nan,
    output logic                out_valid,
    output logic [DE+DF:0]      out_word,
    output logic                out_invalid
);
    localparam int DROP   = SF - DF;
    localparam int DW     = DE + DF + 1;
    localparam int BIAS_S = (1 << (SE - 1)) - 1;
    localparam int BIAS_D = (1 << (DE - 1)) - 1;
    localparam int OVF_E  = BIAS_S + BIAS_D + 1;

    logic              sgn;
    logic [SE-1:0]     exp_f;
    logic [SF-1:0]     frac_f;
    kind_e             kind;
    logic [DE+DF-1:0]  mag;
    logic [DW-1:0]     res;
    logic              res_inv;

    assign sgn    = in_word[SE+SF];
    assign exp_f  = in_word[SE+SF-1:SF];
    assign frac_f = in_word[SF-1:0];

    hpn_classify #(.SE(SE), .SF(SF)) u_cls (
        .exp_i  (exp_f),
        .frac_i (frac_f),
        .kind_o (kind)
    );

    hpn_round #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_rnd (
        .exp_i  (exp_f),
        .frac_i (frac_f),
        .mag_o  (mag)
    );

    always_comb begin
        res_inv = 1'b0;
        unique case (kind)
            K_ZERO, K_TINY: res = {sgn, {(DE+DF){1'b0}}};
            K_INF:          res = {sgn, {DE{1'b1}}, {DF{1'b0}}};
            K_QNAN, K_SNAN: begin
                res_inv = (kind == K_SNAN);
                if (dflt_nan) res = {1'b0, {DE{1'b1}}, 1'b1, {(DF-1){1'b0}}};
                else          res = {sgn, {DE{1'b1}}, 1'b1, frac_f[SF-2:DROP]};
            end
            default:        res = {sgn, mag};
        endcase
    end

    hpn_out_stage #(.DW(DW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_valid),
        .d_word (res),
        .d_inv  (res_inv),
        .valid  (out_valid),
        .word   (out_word),
        .inv    (out_invalid)
    );

    // R1
    lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[SE+SF-1:0] == '0) |=>
        out_word == {$past(in_word[SE+SF]), {(DE+DF){1'b0}}});

    // R3
    inf_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[SE+SF-1:SF] == '1 && in_word[SF-1:0] == '0) |=>
        out_word[DE+DF-1:0] == {{DE{1'b1}}, {DF{1'b0}}});

    // R5
    dflt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_nan && in_word[SE+SF-1:SF] == '1 && in_word[SF-1:0] != '0) |=>
        out_word == {1'b0, {DE{1'b1}}, 1'b1, {(DF-1){1'b0}}});

    // R6
    snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_invalid == $past(in_word[SE+SF-1:SF] == '1 &&
                                          !in_word[SF-1] && in_word[SF-1:0] != '0));

    // R8
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[SE+SF-1:SF] != '1 && int'(in_word[SE+SF-1:SF]) >= OVF_E) |=>
        out_word[DE+DF-1:0] == {{DE{1'b1}}, {DF{1'b0}}});

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_word) && $stable(out_invalid)));
endmodule

// File: tb/test_sp_to_hp_narrow.sv
module test_sp_to_hp_narrow;
    typedef struct {
        logic [15:0] w;
        logic        inv;
        int          req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        dflt_nan = 1'b0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        out_invalid;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   have_last = 1'b0;
    logic [15:0] last_w = '0;
    logic        last_inv = 1'b0;

    always #2 clk = ~clk;

    sp_to_hp_narrow i_sp_to_hp_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .dflt_nan(dflt_nan), .out_valid(out_valid), .out_word(out_word),
        .out_invalid(out_invalid)
    );

    task automatic check(input int req, input logic [16:0] act, input logic [16:0] expv,
                         input logic [31:0] opnd);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL R%0d operand=%h actual=%h expected=%h", req, opnd, act, expv);
        end
    endtask

    task automatic model(input logic [31:0] x, input logic dn,
                         output logic [15:0] w, output logic inv, output int req);
        int       ex;
        int       e;
        int       sh;
        longint   sig, quot, rem, half, mag;
        logic     s;
        s  = x[31];
        ex = int'(x[30:23]);
        inv = 1'b0;
        if (ex == 255 && x[22:0] != 0) begin
            inv = !x[22];                          // R6
            if (dn) begin w = 16'h7E00; req = 5; end // R5
            else begin w = {s, 5'h1F, 1'b1, x[21:13]}; req = 4; end // R4
        end else if (ex == 255) begin
            w = {s, 15'h7C00}; req = 3;            // R3
        end else if (ex == 0) begin
            w = {s, 15'h0}; req = (x[22:0] == 0) ? 2 : 10; // R2 R10
        end else begin
            e   = ex - 127;
            sig = longint'(x[22:0]) | (64'd1 << 23);
            req = (e >= -14) ? 7 : 9;              // R7 R9
            if (e > 15) mag = 64'h7C00;
            else begin
                sh = (e >= -14) ? 13 : (-1 - e);
                if (sh > 40) quot = 0;
                else begin
                    quot = sig >> sh;
                    rem  = sig & ((64'd1 << sh) - 1);
                    half = 64'd1 << (sh - 1);
                    if (rem > half || (rem == half && quot[0])) quot++;
                end
                mag = (e >= -14) ? ((longint'(e + 15) << 10) + quot - 1024) : quot;
            end
            if (mag >= 64'h7C00) begin mag = 64'h7C00; req = 8; end // R8
            w = {s, mag[14:0]};
        end
    endtask

    task automatic push(input logic [31:0] x, input logic dn, input logic [15:0] w,
                        input logic inv, input int req);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; in_word = x; dflt_nan = dn;
        it.w = w; it.inv = inv; it.req = req;
        q.push_back(it);
    endtask

    task automatic send(input logic [31:0] x, input logic dn);
        logic [15:0] w; logic inv; int req;
        model(x, dn, w, inv, req);
        push(x, dn, w, inv, req);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_word = $urandom; dflt_nan = $urandom;
        end
    endtask

    // monitor
    initial begin
        exp_t it;
        logic [31:0] dummy;
        dummy = '0;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        check(1, 17'h1, 17'h0, dummy); // R1 strobe without operand
                    end else begin
                        it = q.pop_front();
                        check(it.req, {out_invalid, out_word}, {it.inv, it.w}, dummy);
                        last_w = it.w; last_inv = it.inv; have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check(11, {out_invalid, out_word}, {last_inv, last_w}, dummy); // R11
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(1, {out_valid, out_word}, 17'h0, 32'h0);
        check(1, {16'h0, out_invalid}, 17'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, {out_valid, out_word}, 17'h0, 32'h0);

        // R2 zeros, R10 single subnormals
        push(32'h0000_0000, 1'b0, 16'h0000, 1'b0, 2);
        push(32'h8000_0000, 1'b0, 16'h8000, 1'b0, 2);
        push(32'h0000_0001, 1'b0, 16'h0000, 1'b0, 10);
        push(32'h8040_0000, 1'b0, 16'h8000, 1'b0, 10);
        // R3 infinities
        push(32'h7F80_0000, 1'b0, 16'h7C00, 1'b0, 3);
        push(32'hFF80_0000, 1'b1, 16'hFC00, 1'b0, 3);
        // R4 payload NaNs, R6 signalling flag
        push(32'h7FC0_0001, 1'b0, 16'h7E00, 1'b0, 4);
        push(32'h7FD5_5555, 1'b0, 16'h7EAA, 1'b0, 4);
        push(32'h7F80_0001, 1'b0, 16'h7E00, 1'b1, 6);
        push(32'hFFA0_0000, 1'b0, 16'hFF00, 1'b1, 6);
        // R5 default NaN
        push(32'hFFA0_0000, 1'b1, 16'h7E00, 1'b1, 5);
        push(32'hFFFF_FFFF, 1'b1, 16'h7E00, 1'b0, 5);
        idle(3);
        // R7 rounding ties and carries
        push(32'h3F80_0000, 1'b0, 16'h3C00, 1'b0, 7);
        push(32'h3F80_1000, 1'b0, 16'h3C00, 1'b0, 7);
        push(32'h3F80_3000, 1'b0, 16'h3C02, 1'b0, 7);
        push(32'h3F80_1001, 1'b0, 16'h3C01, 1'b0, 7);
        push(32'h3FFF_F000, 1'b0, 16'h4000, 1'b0, 7);
        push(32'h477F_E000, 1'b0, 16'h7BFF, 1'b0, 7);
        // R8 overflow
        push(32'h477F_F000, 1'b0, 16'h7C00, 1'b0, 8);
        push(32'hC780_0000, 1'b0, 16'hFC00, 1'b0, 8);
        push(32'h7F7F_FFFF, 1'b0, 16'h7C00, 1'b0, 8);
        // R9 half subnormal range
        push(32'h3880_0000, 1'b0, 16'h0400, 1'b0, 7);
        push(32'h387F_F000, 1'b0, 16'h0400, 1'b0, 9);
        push(32'h3380_0000, 1'b0, 16'h0001, 1'b0, 9);
        push(32'h3300_0000, 1'b0, 16'h0000, 1'b0, 9);
        push(32'h3300_0001, 1'b0, 16'h0001, 1'b0, 9);
        push(32'hB3C0_0000, 1'b0, 16'h8002, 1'b0, 9);
        push(32'h2000_0000, 1'b0, 16'h0000, 1'b0, 9);
        idle(2);

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] x;
            x = $urandom;
            if (k % 3 != 0) x[30:23] = 8'(100 + ($urandom % 46));
            send(x, 1'(k % 5 == 0));
            if (k % 17 == 0) idle(1 + k % 3);
        end
        idle(4);
        done = 1'b1;
        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing results actual=%0d expected=0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule